// File: doc/BRIEF.md
# Multiplexed Address/Data Burst Sequencer

This block moves DMA-style transfer units over one shared 32-bit address/data bus. Every access opens with a single address cycle. In that cycle the top three bus bits hold a code for the transfer size and the lower bits hold the address. One or more data cycles then follow, and each of them carries one 32-bit beat.

Units of 1, 2 and 4 bytes take one data cycle each. A 16-byte unit depends on a burst-mode bit:
- With the bit clear, the unit goes out as one access of four beats.
- With the bit set, the unit is split into two accesses of two beats each, and the second access is addressed 8 bytes above the first.

A ready input stretches each data cycle. A one-cycle completion pulse marks the end of the whole unit. The block takes a new request only while it is idle, and it signals busy otherwise.

Top module: `mux_burst_seq`

## Requirements
- R1: After reset the block is idle:
  - `busy`, `ad_addr_vld`, `ad_data_vld` and `done` are low.
  - `bus_ad` is zero.
- R2: Request acceptance and busy:
  - A request (`req_valid` high) is taken at a clock edge only while `busy` is low.
  - `busy` is high from the cycle after acceptance through the last data cycle.
  - Requests presented while busy are ignored.
- R3: Address cycle:
  - The first address cycle comes in the cycle after acceptance and lasts exactly one clock.
  - In it `ad_addr_vld` is high, `ad_data_vld` is low, `bus_ad[31:29]` holds the size code and `bus_ad[28:0]` holds the access address bits 28..0.
  - The cycle after every address cycle is a data cycle.
- R4: Size codes on `bus_ad[31:29]`, with `req_size` encoded 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 16 bytes:
  - 000 for 1 byte, 001 for 2 bytes, 010 for 4 bytes.
  - 100 for 16 bytes with the mode bit at 0.
  - 011 (8 bytes) for each access of a 16-byte unit with the mode bit at 1.
  - Codes 101 to 111 never appear.
- R5: A 1-, 2- or 4-byte unit has one access with exactly one data cycle, whatever the mode bit holds. Its data sits in the low lanes of `bus_ad` and the unused upper bits are zero.
- R6: A 16-byte unit with the mode bit at 0 is one access of four data cycles. Beat k carries `req_wdata[32k+31:32k]`.
- R7: A 16-byte unit with the mode bit at 1 is two accesses:
  - Each access has its own address cycle with code 011 and two data cycles.
  - The second address is the first plus 8, modulo 2^32.
  - The beats carry `req_wdata` words 0, 1, 2, 3 in that order.
- R8: A data cycle holds `bus_ad` and `ad_data_vld` unchanged while `bus_rdy` is low. It advances only at an edge where `bus_rdy` is high.
- R9: `done` is high for exactly one clock, in the cycle after the last data cycle of the whole unit. It is never raised between the two accesses of a split unit.
- R10: The mode bit, size, address and data are sampled at acceptance. Changes on those inputs during a transfer have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request |
| req_addr | input | 32 | Start address of the unit |
| req_size | input | 2 | Unit size: 0=1B, 1=2B, 2=4B, 3=16B |
| req_wdata | input | 128 | Write data; word k goes out on beat k |
| req_half | input | 1 | Burst mode: 0 = four-beat, 1 = two two-beat accesses |
| bus_rdy | input | 1 | Ready; ends the current data cycle |
| busy | output | 1 | Sequencer is occupied; requests ignored |
| bus_ad | output | 32 | Multiplexed address/data bus |
| ad_addr_vld | output | 1 | Address cycle strobe |
| ad_data_vld | output | 1 | Data cycle strobe |
| done | output | 1 | One-cycle completion pulse per unit |

## Verification
The bench targets these corner cases:
- **Split 16-byte unit.** A design that raised `done` after the first access, reused the first address, or emitted code 100 would show a wrong pulse or a wrong address word.
- **Narrow units with the mode bit set.** A design that let the mode bit reach narrow units would produce extra beats, or stray upper bytes on the bus.
- **Long ready stalls.** These catch a beat that advances early or a bus that changes mid-stall.
- **Address wrap and requests raised during busy.** A start address just below the 4 GB boundary checks the +8 step. Requests raised while busy would, if wrongly accepted, restart the address cycle or corrupt the latched unit.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  localparam int BEAT_W     = 32;
  localparam int UNIT_BEATS = 4;
  localparam int CODE_W     = 3;
  localparam int BIDX_W     = $clog2(UNIT_BEATS);
  localparam int UNIT_W     = BEAT_W * UNIT_BEATS;
  localparam int BEAT_BYTES = BEAT_W / 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_UNIT = 2'd3
  } xfer_size_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  // size code driven in the top bits during an address cycle
  function automatic logic [CODE_W-1:0] size_code(xfer_size_e s, logic half);
    case (s)
      SZ_BYTE: size_code = 3'b000;
      SZ_HALF: size_code = 3'b001;
      SZ_WORD: size_code = 3'b010;
      default: size_code = half ? 3'b011 : 3'b100;
    endcase
  endfunction

  function automatic logic [BIDX_W:0] beats_per_access(xfer_size_e s, logic half);
    if (s != SZ_UNIT) beats_per_access = (BIDX_W+1)'(1);
    else if (half)    beats_per_access = (BIDX_W+1)'(UNIT_BEATS / 2);
    else              beats_per_access = (BIDX_W+1)'(UNIT_BEATS);
  endfunction

  function automatic logic [BIDX_W:0] beats_per_unit(xfer_size_e s);
    beats_per_unit = (s == SZ_UNIT) ? (BIDX_W+1)'(UNIT_BEATS) : (BIDX_W+1)'(1);
  endfunction

  // beat k of the latched payload, narrow sizes zero-extended in low lanes
  function automatic logic [BEAT_W-1:0] lane_data(xfer_size_e s,
                                                  logic [UNIT_W-1:0] wd,
                                                  logic [BIDX_W-1:0] k);
    case (s)
      SZ_BYTE: lane_data = BEAT_W'(wd[7:0]);
      SZ_HALF: lane_data = BEAT_W'(wd[15:0]);
      SZ_WORD: lane_data = wd[BEAT_W-1:0];
      default: lane_data = wd[k*BEAT_W +: BEAT_W];
    endcase
  endfunction
endpackage

// File: rtl/mbs_ctrl.sv
module mbs_ctrl
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    req_addr,
  input  xfer_size_e           req_size,
  input  logic [UNIT_W-1:0]    req_wdata,
  input  logic                 req_half,
  input  logic                 bus_rdy,
  output phase_e               ph,
  output logic [BIDX_W-1:0]    beat_q,
  output logic [ADDR_W-1:0]    lat_addr,
  output xfer_size_e           lat_size,
  output logic [UNIT_W-1:0]    lat_wdata,
  output logic                 lat_half,
  output logic                 done_q
);
  logic [BIDX_W:0] bpa, bpu, beat_nx;
  logic            evt_accept, evt_beat, evt_acc_last, evt_unit_last;

  assign bpa           = beats_per_access(lat_size, lat_half);
  assign bpu           = beats_per_unit(lat_size);
  assign beat_nx       = {1'b0, beat_q} + (BIDX_W+1)'(1);
  assign evt_accept    = (ph == PH_IDLE) && req_valid;
  assign evt_beat      = (ph == PH_DATA) && bus_rdy;
  assign evt_acc_last  = (beat_nx & (bpa - (BIDX_W+1)'(1))) == '0;
  assign evt_unit_last = beat_nx == bpu;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      beat_q    <= '0;
      lat_addr  <= '0;
      lat_size  <= SZ_BYTE;
      lat_wdata <= '0;
      lat_half  <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= evt_beat && evt_unit_last;
      case (ph)
        PH_IDLE: if (evt_accept) begin
          lat_addr  <= req_addr;
          lat_size  <= req_size;
          lat_wdata <= req_wdata;
          lat_half  <= req_half;
          beat_q    <= '0;
          ph        <= PH_ADDR;
        end
        PH_ADDR: ph <= PH_DATA;
        PH_DATA: if (bus_rdy) begin
          if (evt_unit_last) begin
            ph <= PH_IDLE;
          end else begin
            beat_q <= beat_nx[BIDX_W-1:0];
            ph     <= evt_acc_last ? PH_ADDR : PH_DATA;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |=> ph == PH_ADDR); // R2
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != PH_IDLE) |=> $stable(lat_addr) && $stable(lat_wdata)); // R2
  AST_ADDR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_ADDR) |=> ph == PH_DATA); // R3
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph == PH_DATA) && !bus_rdy) |=> (ph == PH_DATA) && $stable(beat_q)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ph == PH_IDLE); // R9
  AST_MODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != PH_IDLE) |=> $stable(lat_half) && $stable(lat_size)); // R10
endmodule

// File: rtl/mbs_bus_mux.sv
module mbs_bus_mux
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_rdy,
  input  phase_e               ph,
  input  logic [BIDX_W-1:0]    beat_q,
  input  logic [ADDR_W-1:0]    lat_addr,
  input  xfer_size_e           lat_size,
  input  logic [UNIT_W-1:0]    lat_wdata,
  input  logic                 lat_half,
  output logic [BEAT_W-1:0]    bus_ad,
  output logic                 ad_addr_vld,
  output logic                 ad_data_vld
);
  localparam int LOW_W = BEAT_W - CODE_W;

  logic [ADDR_W-1:0] acc_addr;
  logic [CODE_W-1:0] code;

  // beat index times beat size: +8 for the second half of a split unit
  assign acc_addr    = lat_addr + ADDR_W'(beat_q) * ADDR_W'(BEAT_BYTES);
  assign code        = size_code(lat_size, lat_half);
  assign ad_addr_vld = (ph == PH_ADDR);
  assign ad_data_vld = (ph == PH_DATA);

  always_comb begin
    case (ph)
      PH_ADDR: bus_ad = {code, acc_addr[LOW_W-1:0]};
      PH_DATA: bus_ad = lane_data(lat_size, lat_wdata, beat_q);
      default: bus_ad = '0;
    endcase
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ad_addr_vld && ad_data_vld)); // R3
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ad_addr_vld |-> bus_ad[BEAT_W-1 -: CODE_W] <= 3'b100); // R4
  AST_CODE16_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_addr_vld && bus_ad[BEAT_W-1 -: CODE_W] == 3'b100) |-> !lat_half); // R4
  AST_CODE8_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_addr_vld && bus_ad[BEAT_W-1 -: CODE_W] == 3'b011) |-> lat_half); // R4
  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_data_vld && !bus_rdy) |=> ad_data_vld && $stable(bus_ad)); // R8
endmodule

// File: rtl/mux_burst_seq.sv
module mux_burst_seq
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [1:0]           req_size,
  input  logic [UNIT_W-1:0]    req_wdata,
  input  logic                 req_half,
  input  logic                 bus_rdy,
  output logic                 busy,
  output logic [BEAT_W-1:0]    bus_ad,
  output logic                 ad_addr_vld,
  output logic                 ad_data_vld,
  output logic                 done
);
  phase_e            ph;
  logic [BIDX_W-1:0] beat_q;
  logic [ADDR_W-1:0] lat_addr;
  xfer_size_e        lat_size;
  logic [UNIT_W-1:0] lat_wdata;
  logic              lat_half;

  mbs_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_size  (xfer_size_e'(req_size)),
    .req_wdata (req_wdata),
    .req_half  (req_half),
    .bus_rdy   (bus_rdy),
    .ph        (ph),
    .beat_q    (beat_q),
    .lat_addr  (lat_addr),
    .lat_size  (lat_size),
    .lat_wdata (lat_wdata),
    .lat_half  (lat_half),
    .done_q    (done)
  );

  mbs_bus_mux #(.ADDR_W(ADDR_W)) u_mux (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_rdy     (bus_rdy),
    .ph          (ph),
    .beat_q      (beat_q),
    .lat_addr    (lat_addr),
    .lat_size    (lat_size),
    .lat_wdata   (lat_wdata),
    .lat_half    (lat_half),
    .bus_ad      (bus_ad),
    .ad_addr_vld (ad_addr_vld),
    .ad_data_vld (ad_data_vld)
  );

  assign busy = (ph != PH_IDLE);

  AST_BUSY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
endmodule

// File: tb/mux_burst_seq_test.sv
module mux_burst_seq_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [31:0]  req_addr = '0;
  logic [1:0]   req_size = '0;
  logic [127:0] req_wdata = '0;
  logic         req_half = 1'b0;
  logic         bus_rdy = 1'b0;
  logic         busy;
  logic [31:0]  bus_ad;
  logic         ad_addr_vld, ad_data_vld, done;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mux_burst_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata), .req_half(req_half),
    .bus_rdy(bus_rdy), .busy(busy), .bus_ad(bus_ad),
    .ad_addr_vld(ad_addr_vld), .ad_data_vld(ad_data_vld), .done(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R4 code table, restated
  function automatic logic [2:0] exp_code(logic [1:0] sz, logic half);
    if (sz == 2'd3) return half ? 3'd3 : 3'd4;
    return {1'b0, sz};
  endfunction

  // R5 / R6 / R7 beat contents
  function automatic logic [31:0] exp_beat(logic [1:0] sz, logic [127:0] wd, int k);
    case (sz)
      2'd0: return wd[31:0] & 32'h0000_00FF;
      2'd1: return wd[31:0] & 32'h0000_FFFF;
      2'd2: return wd[31:0];
      default: return wd[32*k +: 32];
    endcase
  endfunction

  // one full unit; rdy_pct = chance (0..100) that ready is high in a data cycle
  task automatic run_unit(input logic [31:0] a, input logic [1:0] sz,
                          input logic half, input logic [127:0] wd, input int rdy_pct);
    int n_acc, n_bpa;
    logic [31:0] acc_a;
    n_acc = (sz == 2'd3 && half) ? 2 : 1;
    n_bpa = (sz == 2'd3) ? (half ? 2 : 4) : 1;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_half = half; req_wdata = wd;
    bus_rdy = 1'b0;
    @(negedge clk);
    // R10: scramble the request inputs after acceptance
    req_valid = 1'b0; req_addr = $urandom; req_half = ~half; req_size = 2'($urandom);
    req_wdata = {$urandom, $urandom, $urandom, $urandom};
    for (int ac = 0; ac < n_acc; ac++) begin
      acc_a = a + 32'(ac * 8);
      chk("R3 addr strobe", {31'b0, ad_addr_vld}, 32'd1);
      chk("R3 data strobe low in addr cycle", {31'b0, ad_data_vld}, 32'd0);
      chk("R4/R7 addr word", bus_ad, {exp_code(sz, half), acc_a[28:0]});
      chk("R2 busy", {31'b0, busy}, 32'd1);
      chk("R9 no done mid-unit", {31'b0, done}, 32'd0);
      req_valid = 1'b1;             // R2: request while busy must be ignored
      bus_rdy = 1'($urandom);
      @(negedge clk);
      req_valid = 1'b0;
      for (int b = 0; b < n_bpa; b++) begin
        logic r;
        do begin
          chk("R8 data strobe", {31'b0, ad_data_vld}, 32'd1);
          chk("R3 addr strobe low in data", {31'b0, ad_addr_vld}, 32'd0);
          chk("R5/R6/R7/R8 data beat", bus_ad, exp_beat(sz, wd, ac * n_bpa + b));
          chk("R9 no done in data", {31'b0, done}, 32'd0);
          r = (($urandom % 100) < rdy_pct);
          bus_rdy = r;
          @(negedge clk);
        end while (!r);
      end
    end
    bus_rdy = 1'b0;
    chk("R9 done pulse", {31'b0, done}, 32'd1);
    chk("R2 busy clears", {31'b0, busy}, 32'd0);
    chk("R5/R6 no extra cycle", {30'b0, ad_addr_vld, ad_data_vld}, 32'd0);
    @(negedge clk);
    chk("R9 done single", {31'b0, done}, 32'd0);
    chk("R2 stays idle", {31'b0, busy}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0123));
    repeat (3) @(negedge clk);
    chk("R1 busy", {31'b0, busy}, 32'd0);
    chk("R1 strobes", {30'b0, ad_addr_vld, ad_data_vld}, 32'd0);
    chk("R1 done", {31'b0, done}, 32'd0);
    chk("R1 bus", bus_ad, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    // directed: every size, both modes, ready always high
    for (int s = 0; s < 4; s++)
      for (int h = 0; h < 2; h++)
        run_unit(32'h1234_5670 + 32'(s * 16), 2'(s), 1'(h),
                 128'hDDDD_DDDD_CCCC_CCCC_BBBB_BBBB_A1B2_C3D4, 100);
    // R7 with the +8 step wrapping past the top of the address space
    run_unit(32'hFFFF_FFF8, 2'd3, 1'b1, 128'h4444_0000_3333_0000_2222_0000_1111_0000, 100);
    // R8 long stalls
    run_unit(32'h0000_0100, 2'd3, 1'b0, 128'h0F0E_0D0C_0B0A_0908_0706_0504_0302_0100, 10);
    run_unit(32'h0000_0200, 2'd3, 1'b1, 128'h1F1E_1D1C_1B1A_1918_1716_1514_1312_1110, 10);
    // random mix
    for (int i = 0; i < 60; i++)
      run_unit($urandom, 2'($urandom), 1'($urandom),
               {$urandom, $urandom, $urandom, $urandom}, 20 + int'($urandom % 81));
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule